// File: doc/BRIEF.md
# Transmit Byte Buffer with Threshold Refill

This block sits between a 16-bit DMA write port and an 8-bit serializer on the transmit side of a network controller. It holds 32 bytes as eight rows of four byte lanes. The DMA side writes one half-word at a time into the lower or upper half of a row. A read machine walks the bytes in stream order and sends one byte per cycle to the serializer. It chooses the physical lane of each byte from the configured byte order.

Threshold logic controls both sides. It raises a refill request whenever the stored byte count is at or below a programmable threshold. A grant opens a write burst, whose length depends on the mode. In block mode the burst is the threshold amount; in empty-fill mode it fills all free space. Serial output begins only once the count is strictly above the threshold, or once the final half-word of the packet has been written.

A packet may begin on the second byte of its first half-word or end on the first byte of its last half-word. Sideband inputs say which case applies, and the padding bytes are dropped from the stream. If the buffer runs dry after output has started and before the last valid byte has gone out, a sticky underrun flag is set.

Top module: `tx_thresh_fifo`

## Requirements
- R1: In little-endian mode (cfg_big_endian_i=0) each written half-word yields bits [7:0] then bits [15:8] on byte_o. Half-words come out in the order they were written.
- R2: In big-endian mode (cfg_big_endian_i=1) each written half-word yields bits [15:8] then bits [7:0] on byte_o.
- R3: No byte is emitted while the stored byte count equals the threshold. Output starts only once the count is strictly greater than the threshold.
- R4: dma_req_o is high while a packet is active, no burst is open, the final half-word has not been written and the byte count is at or below the threshold. It drops after a grant, and it stays low once the packet is complete.
- R5: cfg_thr_i encodes the threshold as 0=4 bytes, 1=8 bytes, 2=16 bytes and 3=24 bytes.
- R6: In block mode (cfg_empty_fill_i=0) a grant opens a burst of threshold/2 half-words, capped by the free space. A write with dma_last_i closes the burst early.
- R7: In empty-fill mode a grant opens a burst equal to the free half-word slots, which is 16 from empty. Occupancy never exceeds 32 bytes.
- R8: With pkt_start_odd_i=1 the first stream byte of the first half-word is dropped. With pkt_end_odd_i=1 the second stream byte of the last half-word is dropped. byte_last_o marks the final valid byte.
- R9: A packet whose whole content fits at or below the threshold still starts once its final half-word has been written.
- R10: Once started, output continues every cycle while data is stored. An empty buffer before the final byte sets underrun_o. The flag holds until the next pkt_start_i.
- R11: dma_wr_i while no burst is open is ignored.
- R12: After reset dma_req_o, dma_open_o, byte_valid_o, byte_last_o and underrun_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_big_endian_i | input | 1 | Byte order: 1 = big-endian |
| cfg_empty_fill_i | input | 1 | Refill mode: 1 = fill free space, 0 = threshold-sized bursts |
| cfg_thr_i | input | 2 | Threshold code |
| pkt_start_i | input | 1 | Pulse: begin a new packet, clear pointers and flags |
| pkt_start_odd_i | input | 1 | First half-word carries one leading pad byte |
| pkt_end_odd_i | input | 1 | Last half-word carries one trailing pad byte |
| dma_req_o | output | 1 | Refill request |
| dma_gnt_i | input | 1 | Grant pulse, taken while dma_req_o is high |
| dma_open_o | output | 1 | Burst open: writes accepted |
| dma_wr_i | input | 1 | Half-word write strobe |
| dma_data_i | input | 16 | Half-word write data |
| dma_last_i | input | 1 | This write is the packet's final half-word |
| byte_o | output | 8 | Byte to serializer |
| byte_valid_o | output | 1 | byte_o holds a packet byte |
| byte_last_o | output | 1 | byte_o is the final packet byte |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The hardest state to reach is a buffer that has started output and then runs dry mid-packet. A DMA side that answers every request promptly never lets this happen. The bench caps the number of grants it answers, so that the stored bytes drain and underrun_o rises. It then lifts the cap and checks that the rest of the packet still arrives and that the flag stays set. The same cap, set to one grant with an 8-byte threshold and a 4-half-word burst, holds the count exactly at the threshold. This exposes the strict start rule and the at-or-below request rule together.

// File: rtl/tx_thresh_pkg.sv
package tx_thresh_pkg;
  localparam int LANES = 4;

  function automatic logic [5:0] thr_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd4;
      2'd1:    return 6'd8;
      2'd2:    return 6'd16;
      default: return 6'd24;
    endcase
  endfunction

  // stream position k within a row -> physical lane
  function automatic logic [1:0] lane_of(input logic big, input logic [1:0] k);
    return big ? (2'd3 - k) : k;
  endfunction
endpackage

// File: rtl/tx_thresh_store.sv
module tx_thresh_store
  import tx_thresh_pkg::*;
#(
  parameter int ROWS = 8,
  localparam int DEPTH = ROWS * LANES,
  localparam int AW = $clog2(DEPTH),
  localparam int HWW = AW - 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           big_i,
  input  logic           wr_en_i,
  input  logic [HWW-1:0] wr_hw_i,
  input  logic [15:0]    wr_data_i,
  input  logic [1:0]     wr_vld_i,
  input  logic [1:0]     wr_eop_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [7:0]     rd_byte_o,
  output logic           rd_vld_o,
  output logic           rd_eop_o
);
  localparam int RW = $clog2(ROWS);

  logic [7:0]       mem_q [ROWS][LANES];
  logic [DEPTH-1:0] vld_q, eop_q;
  logic [RW-1:0]    wr_row, rd_row;
  logic [1:0]       k0, k1;
  logic [7:0]       b_first, b_second;
  logic [7:0]       lane_byte [LANES];

  assign wr_row   = wr_hw_i[HWW-1:1];
  assign k0       = {wr_hw_i[0], 1'b0};
  assign k1       = {wr_hw_i[0], 1'b1};
  assign b_first  = big_i ? wr_data_i[15:8] : wr_data_i[7:0];
  assign b_second = big_i ? wr_data_i[7:0]  : wr_data_i[15:8];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_q[wr_row][lane_of(big_i, k0)] <= b_first;
      mem_q[wr_row][lane_of(big_i, k1)] <= b_second;
    end
  end

  // per-byte flags kept in stream order
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      eop_q <= '0;
    end else if (wr_en_i) begin
      vld_q[{wr_hw_i, 1'b0}] <= wr_vld_i[0];
      vld_q[{wr_hw_i, 1'b1}] <= wr_vld_i[1];
      eop_q[{wr_hw_i, 1'b0}] <= wr_eop_i[0];
      eop_q[{wr_hw_i, 1'b1}] <= wr_eop_i[1];
    end
  end

  assign rd_row = rd_addr_i[AW-1:2];

  for (genvar k = 0; k < LANES; k++) begin : g_rd_ptr
    assign lane_byte[k] = mem_q[rd_row][lane_of(big_i, 2'(k))];
  end

  assign rd_byte_o = lane_byte[rd_addr_i[1:0]];
  assign rd_vld_o  = vld_q[rd_addr_i];
  assign rd_eop_o  = eop_q[rd_addr_i];
endmodule

// File: rtl/tx_thresh_flow.sv
module tx_thresh_flow
  import tx_thresh_pkg::*;
#(
  parameter int ROWS = 8,
  localparam int DEPTH = ROWS * LANES,
  localparam int AW = $clog2(DEPTH),
  localparam int HWW = AW - 1,
  localparam int CW = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     cfg_thr_i,
  input  logic           cfg_empty_fill_i,
  input  logic           pkt_start_i,
  input  logic           start_odd_i,
  input  logic           end_odd_i,
  input  logic           dma_gnt_i,
  input  logic           dma_wr_i,
  input  logic           dma_last_i,
  input  logic           rd_eop_i,
  output logic           dma_req_o,
  output logic           dma_open_o,
  output logic           wr_en_o,
  output logic [HWW-1:0] wr_hw_o,
  output logic [1:0]     wr_vld_o,
  output logic [1:0]     wr_eop_o,
  output logic           rd_fire_o,
  output logic [AW-1:0]  rd_addr_o,
  output logic           underrun_o,
  output logic [CW-1:0]  count_o
);
  logic [HWW:0]  wr_q;
  logic [AW:0]   rd_q;
  logic [CW-1:0] count, thr, free_hw, blk_hw, burst_len, rem_q;
  logic active_q, run_q, open_q, last_wr_q, fin_q, under_q, first_q;
  logic wr_fire, rd_fire;

  assign count     = {wr_q, 1'b0} - rd_q;
  assign thr       = CW'(thr_bytes(cfg_thr_i));
  assign free_hw   = (CW'(DEPTH) - count) >> 1;
  assign blk_hw    = ((thr >> 1) < free_hw) ? (thr >> 1) : free_hw;
  assign burst_len = cfg_empty_fill_i ? free_hw : blk_hw;

  assign dma_req_o = active_q && !last_wr_q && !open_q && (count <= thr);
  assign wr_fire   = open_q && dma_wr_i;
  assign rd_fire   = run_q && (count != '0);

  assign wr_vld_o = {!(dma_last_i && end_odd_i), !(first_q && start_odd_i)};
  assign wr_eop_o = {dma_last_i && !end_odd_i, dma_last_i && end_odd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; rem_q <= '0;
      active_q <= 1'b0; run_q <= 1'b0; open_q <= 1'b0; last_wr_q <= 1'b0;
      fin_q <= 1'b0; under_q <= 1'b0; first_q <= 1'b0;
    end else if (pkt_start_i) begin
      wr_q <= '0; rd_q <= '0; rem_q <= '0;
      active_q <= 1'b1; run_q <= 1'b0; open_q <= 1'b0; last_wr_q <= 1'b0;
      fin_q <= 1'b0; under_q <= 1'b0; first_q <= 1'b1;
    end else begin
      if (wr_fire) begin
        wr_q    <= wr_q + 1'b1;
        first_q <= 1'b0;
        if (dma_last_i) last_wr_q <= 1'b1;
      end
      if (dma_req_o && dma_gnt_i) begin
        open_q <= 1'b1;
        rem_q  <= burst_len;
      end else if (wr_fire) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == CW'(1) || dma_last_i) open_q <= 1'b0;
      end
      if (rd_fire) begin
        rd_q <= rd_q + 1'b1;
        if (rd_eop_i) fin_q <= 1'b1;
      end
      // strict start, or whole packet already stored
      if (active_q && !run_q && (count > thr || last_wr_q)) run_q <= 1'b1;
      if (run_q && !fin_q && count == '0) under_q <= 1'b1;
      if (run_q && fin_q && count == '0) begin
        run_q    <= 1'b0;
        active_q <= 1'b0;
      end
    end
  end

  assign dma_open_o = open_q;
  assign wr_en_o    = wr_fire;
  assign wr_hw_o    = wr_q[HWW-1:0];
  assign rd_fire_o  = rd_fire;
  assign rd_addr_o  = rd_q[AW-1:0];
  assign underrun_o = under_q;
  assign count_o    = count;
endmodule

// File: rtl/tx_thresh_out.sv
module tx_thresh_out (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_i,
  input  logic [7:0] byte_i,
  input  logic       vld_i,
  input  logic       eop_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       byte_last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      byte_last_o  <= 1'b0;
    end else begin
      byte_o       <= fire_i ? byte_i : byte_o;
      byte_valid_o <= fire_i && vld_i;
      byte_last_o  <= fire_i && vld_i && eop_i;
    end
  end
endmodule

// File: rtl/tx_thresh_fifo.sv
module tx_thresh_fifo
  import tx_thresh_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_big_endian_i,
  input  logic        cfg_empty_fill_i,
  input  logic [1:0]  cfg_thr_i,
  input  logic        pkt_start_i,
  input  logic        pkt_start_odd_i,
  input  logic        pkt_end_odd_i,
  output logic        dma_req_o,
  input  logic        dma_gnt_i,
  output logic        dma_open_o,
  input  logic        dma_wr_i,
  input  logic [15:0] dma_data_i,
  input  logic        dma_last_i,
  output logic [7:0]  byte_o,
  output logic        byte_valid_o,
  output logic        byte_last_o,
  output logic        underrun_o
);
  localparam int DEPTH = ROWS * LANES;
  localparam int AW = $clog2(DEPTH);
  localparam int HWW = AW - 1;
  localparam int CW = AW + 1;

  logic           wr_en, rd_fire, rd_vld, rd_eop;
  logic [HWW-1:0] wr_hw;
  logic [1:0]     wr_vld, wr_eop;
  logic [AW-1:0]  rd_addr;
  logic [7:0]     rd_byte;
  logic [CW-1:0]  count;

  tx_thresh_flow #(.ROWS(ROWS)) u_flow (
    .clk_i, .rst_ni, .cfg_thr_i, .cfg_empty_fill_i, .pkt_start_i,
    .start_odd_i(pkt_start_odd_i), .end_odd_i(pkt_end_odd_i),
    .dma_gnt_i, .dma_wr_i, .dma_last_i, .rd_eop_i(rd_eop),
    .dma_req_o, .dma_open_o, .wr_en_o(wr_en), .wr_hw_o(wr_hw),
    .wr_vld_o(wr_vld), .wr_eop_o(wr_eop), .rd_fire_o(rd_fire),
    .rd_addr_o(rd_addr), .underrun_o, .count_o(count)
  );

  tx_thresh_store #(.ROWS(ROWS)) u_store (
    .clk_i, .rst_ni, .big_i(cfg_big_endian_i), .wr_en_i(wr_en), .wr_hw_i(wr_hw),
    .wr_data_i(dma_data_i), .wr_vld_i(wr_vld), .wr_eop_i(wr_eop),
    .rd_addr_i(rd_addr), .rd_byte_o(rd_byte), .rd_vld_o(rd_vld), .rd_eop_o(rd_eop)
  );

  tx_thresh_out u_out (
    .clk_i, .rst_ni, .fire_i(rd_fire), .byte_i(rd_byte), .vld_i(rd_vld),
    .eop_i(rd_eop), .byte_o, .byte_valid_o, .byte_last_o
  );
endmodule

// File: rtl/tx_thresh_fifo_chk.sv
module tx_thresh_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pkt_start_i,
  input logic          dma_req_o,
  input logic          dma_gnt_i,
  input logic          dma_open_o,
  input logic          dma_wr_i,
  input logic          dma_last_i,
  input logic          underrun_o,
  input logic [CW-1:0] count_i
);
  AST_OPEN_ON_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && dma_gnt_i && !pkt_start_i) |=> dma_open_o); // R6
  AST_CLOSE_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_open_o && dma_wr_i && dma_last_i && !pkt_start_i) |=> !dma_open_o); // R6
  AST_REQ_DROPS_ON_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && dma_gnt_i && !pkt_start_i) |=> !dma_req_o); // R4
  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !pkt_start_i) |=> underrun_o); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH)); // R7
endmodule

bind tx_thresh_fifo tx_thresh_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pkt_start_i(pkt_start_i),
  .dma_req_o(dma_req_o), .dma_gnt_i(dma_gnt_i), .dma_open_o(dma_open_o),
  .dma_wr_i(dma_wr_i), .dma_last_i(dma_last_i), .underrun_o(underrun_o),
  .count_i(count)
);

// File: tb/tx_thresh_fifo_bench.sv
module tx_thresh_fifo_bench;
  typedef struct packed {
    logic       big;
    logic       ef;
    logic [1:0] thr;
    logic       so;
    logic       eo;
    logic [7:0] n;
  } vec_t;

  // big, empty_fill, thr, start_odd, end_odd, half-words
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd20},
    '{1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 8'd24},
    '{1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 8'd40},
    '{1'b1, 1'b1, 2'd3, 1'b0, 1'b1, 8'd30},
    '{1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 8'd2},
    '{1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 8'd33},
    '{1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 8'd17},
    '{1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big, cfg_ef;
  logic [1:0]  cfg_thr;
  logic        pkt_start, start_odd, end_odd;
  logic        dma_req, dma_gnt, dma_open, dma_wr, dma_last;
  logic [15:0] dma_data;
  logic [7:0]  byte_out;
  logic        byte_valid, byte_last, underrun;

  int checks = 0;
  int failures = 0;
  int n_hw, idx, grants, grant_limit, first_burst, got_n, last_at, exp_n, seed;
  logic saw_under;
  logic [7:0] got [128];
  logic [7:0] exp_b [128];
  logic finished = 1'b0;

  always #5 clk = ~clk;

  tx_thresh_fifo u_tx_thresh_fifo (
    .clk_i(clk), .rst_ni(rst_n), .cfg_big_endian_i(cfg_big), .cfg_empty_fill_i(cfg_ef),
    .cfg_thr_i(cfg_thr), .pkt_start_i(pkt_start), .pkt_start_odd_i(start_odd),
    .pkt_end_odd_i(end_odd), .dma_req_o(dma_req), .dma_gnt_i(dma_gnt),
    .dma_open_o(dma_open), .dma_wr_i(dma_wr), .dma_data_i(dma_data),
    .dma_last_i(dma_last), .byte_o(byte_out), .byte_valid_o(byte_valid),
    .byte_last_o(byte_last), .underrun_o(underrun)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] hw_of(input int i);
    return {8'(seed + 2 * i + 1), 8'(seed + 2 * i)};
  endfunction

  task automatic build_exp();
    exp_n = 0;
    for (int i = 0; i < n_hw; i++) begin
      logic [15:0] h = hw_of(i);
      logic [7:0] f = cfg_big ? h[15:8] : h[7:0];
      logic [7:0] s = cfg_big ? h[7:0] : h[15:8];
      if (!(i == 0 && start_odd)) begin exp_b[exp_n] = f; exp_n++; end
      if (!(i == n_hw - 1 && end_odd)) begin exp_b[exp_n] = s; exp_n++; end
    end
  endtask

  task automatic start_packet(input vec_t v, input int sd);
    @(negedge clk);
    cfg_big = v.big; cfg_ef = v.ef; cfg_thr = v.thr;
    start_odd = v.so; end_odd = v.eo;
    dma_gnt = 1'b0; dma_wr = 1'b0; dma_last = 1'b0;
    pkt_start = 1'b1;
    n_hw = int'(v.n); seed = sd; idx = 0; grants = 0; grant_limit = 1000;
    first_burst = 0; got_n = 0; last_at = -1; saw_under = 1'b0;
    @(negedge clk);
    pkt_start = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    if (byte_valid && got_n < 128) begin
      got[got_n] = byte_out;
      if (byte_last) last_at = got_n;
      got_n++;
    end
    if (underrun) saw_under = 1'b1;
    dma_gnt = dma_req && (grants < grant_limit);
    if (dma_gnt) grants++;
    if (dma_open && idx < n_hw) begin
      dma_wr = 1'b1; dma_data = hw_of(idx); dma_last = (idx == n_hw - 1);
      if (grants == 1) first_burst++;
      idx++;
    end else begin
      dma_wr = 1'b0; dma_last = 1'b0;
    end
  endtask

  task automatic run_to_end();
    for (int c = 0; c < 600 && last_at < 0; c++) step();
    repeat (6) step();
  endtask

  task automatic check_stream(input string tag);
    int bad = 0;
    build_exp();
    chk(got_n == exp_n, {tag, " byte count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) if (got[i] != exp_b[i]) bad++;
    chk(bad == 0, {tag, " byte values"}, bad, 0);
    chk(last_at == exp_n - 1, "R8 last flag position", last_at, exp_n - 1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cfg_big = 1'b0; cfg_ef = 1'b0; cfg_thr = 2'd0; pkt_start = 1'b0;
    start_odd = 1'b0; end_odd = 1'b0; dma_gnt = 1'b0; dma_wr = 1'b0;
    dma_last = 1'b0; dma_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!dma_req && !dma_open, "R12 no request or burst after reset", int'(dma_req), 0);
    chk(!byte_valid && !byte_last && !underrun, "R12 outputs idle after reset",
        int'(byte_valid) + int'(underrun), 0);

    // vector walk: R1 R2 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      vec_t cur = VECS[v];
      int thr_hw;
      int exp_burst;
      start_packet(cur, 37 * v + 5);
      run_to_end();
      check_stream(cur.big ? "R2 big-endian stream" : "R1 little-endian stream");
      case (cur.thr)
        2'd0: thr_hw = 2;
        2'd1: thr_hw = 4;
        2'd2: thr_hw = 8;
        default: thr_hw = 12;
      endcase
      exp_burst = cur.ef ? 16 : thr_hw;
      if (n_hw < exp_burst) exp_burst = n_hw;
      chk(first_burst == exp_burst, cur.ef ? "R7 empty-fill first burst" : "R5 R6 block burst",
          first_burst, exp_burst);
      chk(!saw_under, "R10 no underrun with prompt grants", int'(saw_under), 0);
      chk(!dma_req, "R4 no request after packet complete", int'(dma_req), 0);
    end

    // R11: write outside an open burst is ignored
    start_packet('{1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'd8}, 200);
    @(negedge clk);
    dma_wr = 1'b1; dma_last = 1'b1; dma_data = 16'hDEAD;
    @(negedge clk);
    dma_wr = 1'b0; dma_last = 1'b0;
    chk(dma_req, "R11 stray last write left request up", int'(dma_req), 1);
    run_to_end();
    check_stream("R11 stream unaffected by stray write");

    // R3 R4: count held exactly at the threshold
    start_packet('{1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'd20}, 90);
    grant_limit = 1;
    repeat (40) step();
    chk(got_n == 0, "R3 no output at count equal to threshold", got_n, 0);
    chk(dma_req, "R4 request at count equal to threshold", int'(dma_req), 1);
    grant_limit = 1000;
    run_to_end();
    check_stream("R3 stream after threshold crossed");

    // R9: short packet below threshold still drains
    start_packet('{1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 8'd3}, 60);
    run_to_end();
    check_stream("R9 short packet");

    // R10: starved refill
    start_packet('{1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd20}, 120);
    grant_limit = 2;
    repeat (40) step();
    chk(got_n == 8, "R10 bytes before starvation", got_n, 8);
    chk(underrun, "R10 underrun raised", int'(underrun), 1);
    grant_limit = 1000;
    run_to_end();
    check_stream("R10 stream completes after underrun");
    chk(underrun, "R10 underrun sticky", int'(underrun), 1);
    @(negedge clk);
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    chk(!underrun, "R10 underrun cleared by packet start", int'(underrun), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule